// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block walks a DDR2 SDRAM through its power-up and mode-register programming order after a start strobe. It issues one command per step on a valid/ready command port. Each command carries a command code, a bank number and a mode-register payload. Consecutive commands are separated by a programmable idle gap. The gap after the first NOP is a long power-up wait, counted in clock cycles from a clock-frequency parameter.

Alongside the sequence, the block works out where the bank-select bits sit in the flat system address. The inputs to this are the column-count field, the row-count field, the bank decode mode and the data bus width. A memory controller uses this offset to place mode-register writes at the right address.

The payload inputs and configuration fields are expected to stay stable from start until done. The block adjusts the supplied payloads itself to form the DLL-reset and OCD default/exit variants.

Top module: `ddr2_init_seq`

## Requirements
- R1: A synchronous active-high reset puts the sequencer in idle with `cmd_valid` low and `done` low, including when it is applied in the middle of a sequence.
- R2: After a start in idle (or done), exactly fourteen commands are issued in this order: NOP, NOP, precharge-all, EMRS2, EMRS3, EMRS1, MRS, precharge-all, refresh, refresh, MRS, EMRS1, EMRS1, normal-mode. The command codes are NOP=0, precharge-all=1, mode-register set=2, refresh=3 and normal-mode=4.
- R3: `bank_ofs` equals col + 9, plus (row + 11) only when `cfg_interleave` is 0, plus 1 when `cfg_narrow` is 1 or 2 when it is 0.
- R4: Mode-register sets address their target through `cmd_bank`: 2 for EMRS2, 3 for EMRS3, 1 for each EMRS1 and 0 for each MRS. All other commands carry bank 0.
- R5: Payloads are as follows. EMRS2 carries `emr2_val`. EMRS3 carries zero. The first EMRS1 carries `emr1_val` with bit 0 (DLL disable) and bits 9:7 (OCD field) cleared. The first MRS carries `mr_val` with bit 8 (DLL reset) set, and the second MRS carries it with bit 8 cleared. The second EMRS1 is the first EMRS1 payload with bits 9:7 set. The third EMRS1 is the first EMRS1 payload again. Non-mode-set commands carry zero.
- R6: Between acceptance of the first NOP and assertion of the second, `cmd_valid` stays low for exactly CLK_MHZ*PWRUP_US cycles.
- R7: Between acceptance of every later command and assertion of the next one, `cmd_valid` stays low for exactly GAP_CYC cycles.
- R8: While `cmd_valid` is high and `cmd_ready` is low, the command code, bank and payload hold and `cmd_valid` stays high.
- R9: `done` rises in the cycle after the normal-mode command is accepted. It stays high with `cmd_valid` low until the next start, which clears it.
- R10: A start strobe while a sequence is in progress (during a stalled command or during a gap) has no effect on the command stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a sequence when idle or done |
| cfg_col | input | 2 | Column-count field |
| cfg_row | input | 2 | Row-count field |
| cfg_interleave | input | 1 | 1 = interleaved bank decode, 0 = sequential |
| cfg_narrow | input | 1 | 1 = narrow data bus |
| mr_val | input | MRW | Base mode-register payload |
| emr1_val | input | MRW | Base extended mode register 1 payload |
| emr2_val | input | MRW | Extended mode register 2 payload |
| cmd_ready | input | 1 | Command accepted when high with cmd_valid |
| cmd_valid | output | 1 | Command present |
| cmd_code | output | 3 | Command code |
| cmd_bank | output | BAW | Bank number |
| cmd_data | output | MRW | Mode-register payload |
| bank_ofs | output | OFW | Bit position of the bank field in the flat address |
| done | output | 1 | Sequence complete |

## Verification
The start strobe and the command handshake can coincide. A start can land in the same cycle that a command is stalled, or in the middle of the power-up wait, and either must leave the sequence untouched. The bench provokes this by pulsing start while ready is held low part-way through the sequence and again during the long wait. A scoreboard of fourteen expected commands and the measured idle gaps judge the result: an extra, missing or reordered command, or a shifted gap, shows up as a miscompare. A reset landing mid-sequence and a restart from the done state are also exercised.

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq #(
  parameter int CLK_MHZ     = 125,
  parameter int PWRUP_US    = 200,
  parameter int GAP_CYC     = 4,
  parameter int MRW         = 13,
  parameter int BAW         = 3,
  parameter int OFW         = 5,
  parameter int DLL_EN_BIT  = 0,
  parameter int DLL_RST_BIT = 8,
  parameter int OCD_LSB     = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [1:0]     cfg_col,
  input  logic [1:0]     cfg_row,
  input  logic           cfg_interleave,
  input  logic           cfg_narrow,
  input  logic [MRW-1:0] mr_val,
  input  logic [MRW-1:0] emr1_val,
  input  logic [MRW-1:0] emr2_val,
  input  logic           cmd_ready,
  output logic           cmd_valid,
  output logic [2:0]     cmd_code,
  output logic [BAW-1:0] cmd_bank,
  output logic [MRW-1:0] cmd_data,
  output logic [OFW-1:0] bank_ofs,
  output logic           done
);
  localparam int PWRUP_CYC = CLK_MHZ * PWRUP_US;
  localparam int CW        = $clog2(PWRUP_CYC + 1);
  localparam logic [3:0] LAST = 4'd13;

  localparam logic [2:0] C_NOP  = 3'd0;
  localparam logic [2:0] C_PALL = 3'd1;
  localparam logic [2:0] C_MSET = 3'd2;
  localparam logic [2:0] C_REF  = 3'd3;
  localparam logic [2:0] C_NORM = 3'd4;

  localparam logic [MRW-1:0] ONE1 = {{(MRW-1){1'b0}}, 1'b1};
  localparam logic [MRW-1:0] RST_M = ONE1 << DLL_RST_BIT;
  localparam logic [MRW-1:0] EN_M  = ONE1 << DLL_EN_BIT;
  localparam logic [MRW-1:0] OCD_M = {{(MRW-3){1'b0}}, 3'b111} << OCD_LSB;

  typedef enum logic [1:0] {S_IDLE, S_CMD, S_GAP, S_DONE} st_t;

  st_t           st;
  logic [3:0]    step;
  logic [CW-1:0] cnt;
  logic          fire;

  logic [MRW-1:0] emr1_base;
  assign emr1_base = emr1_val & ~(OCD_M | EN_M);

  assign cmd_valid = (st == S_CMD);
  assign done      = (st == S_DONE);
  assign fire      = cmd_valid && cmd_ready;

  assign bank_ofs = OFW'(cfg_col) + OFW'(9)
                  + (cfg_interleave ? OFW'(0) : OFW'(cfg_row) + OFW'(11))
                  + (cfg_narrow ? OFW'(1) : OFW'(2));

  always_comb begin
    cmd_code = C_NOP;
    cmd_bank = '0;
    cmd_data = '0;
    case (step)
      4'd0, 4'd1: cmd_code = C_NOP;
      4'd2, 4'd7: cmd_code = C_PALL;
      4'd3: begin cmd_code = C_MSET; cmd_bank = BAW'(2); cmd_data = emr2_val; end
      4'd4: begin cmd_code = C_MSET; cmd_bank = BAW'(3); end
      4'd5: begin cmd_code = C_MSET; cmd_bank = BAW'(1); cmd_data = emr1_base; end
      4'd6: begin cmd_code = C_MSET; cmd_data = mr_val | RST_M; end
      4'd8, 4'd9: cmd_code = C_REF;
      4'd10: begin cmd_code = C_MSET; cmd_data = mr_val & ~RST_M; end
      4'd11: begin cmd_code = C_MSET; cmd_bank = BAW'(1); cmd_data = emr1_base | OCD_M; end
      4'd12: begin cmd_code = C_MSET; cmd_bank = BAW'(1); cmd_data = emr1_base; end
      default: cmd_code = C_NORM;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      step <= '0;
      cnt  <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE:
          if (start) begin
            st   <= S_CMD;
            step <= '0;
          end
        S_CMD:
          if (cmd_ready) begin
            if (step == LAST) st <= S_DONE;
            else begin
              st  <= S_GAP;
              cnt <= (step == 4'd0) ? CW'(PWRUP_CYC - 1) : CW'(GAP_CYC - 1);
            end
          end
        default:
          if (cnt == '0) begin
            st   <= S_CMD;
            step <= step + 4'd1;
          end else cnt <= cnt - 1'b1;
      endcase
    end
  end

  // R8
  hold_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_code) && $stable(cmd_bank) && $stable(cmd_data));

  // R7
  gap_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> !cmd_valid);

  // R9
  done_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(fire && cmd_code == C_NORM));

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !cmd_valid);
endmodule

// File: tb/ddr2_init_seq_tb.sv
module ddr2_init_seq_tb;
  localparam int PWRUP = 125 * 200;
  localparam int GAP   = 4;

  logic clk = 0, rst = 1, start = 0, cmd_ready = 1;
  logic [1:0] cfg_col = 0, cfg_row = 0;
  logic cfg_interleave = 0, cfg_narrow = 0;
  logic [12:0] mr_val = 13'h0A53, emr1_val = 13'h0F03, emr2_val = 13'h0080;
  logic cmd_valid, done;
  logic [2:0] cmd_code, cmd_bank;
  logic [12:0] cmd_data;
  logic [4:0] bank_ofs;

  int nchk = 0, nfail = 0;
  int n_acc = 0, gap = 0;
  bit waiting = 0, prev_stall = 0, stall_mode = 0, exp_done = 0;
  logic [18:0] prev_item;
  logic [18:0] q[$];
  int rc = 0;

  always #4 clk = ~clk;

  ddr2_init_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .cfg_col(cfg_col), .cfg_row(cfg_row),
    .cfg_interleave(cfg_interleave), .cfg_narrow(cfg_narrow), .mr_val(mr_val),
    .emr1_val(emr1_val), .emr2_val(emr2_val), .cmd_ready(cmd_ready),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
    .cmd_data(cmd_data), .bank_ofs(bank_ofs), .done(done));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [18:0] exp_item(int i);
    logic [12:0] e1;
    e1 = emr1_val & ~13'h0381;
    case (i)
      0, 1:   return {3'd0, 3'd0, 13'h0};
      2, 7:   return {3'd1, 3'd0, 13'h0};
      3:      return {3'd2, 3'd2, emr2_val};
      4:      return {3'd2, 3'd3, 13'h0};
      5, 12:  return {3'd2, 3'd1, e1};
      6:      return {3'd2, 3'd0, mr_val | 13'h0100};
      8, 9:   return {3'd3, 3'd0, 13'h0};
      10:     return {3'd2, 3'd0, mr_val & ~13'h0100};
      11:     return {3'd2, 3'd1, e1 | 13'h0380};
      default: return {3'd4, 3'd0, 13'h0};
    endcase
  endfunction

  always @(posedge clk) begin
    #2;
    rc++;
    cmd_ready = !stall_mode || (rc % 4 != 0 && rc % 7 != 0);
  end

  always @(negedge clk) begin
    logic [18:0] cur, e;
    cur = {cmd_code, cmd_bank, cmd_data};
    if (rst) begin
      waiting = 0; prev_stall = 0; exp_done = 0; n_acc = 0; gap = 0;
    end else begin
      if (exp_done) begin
        chk(done === 1'b1, "R9 done after normal", done, 1);
        exp_done = 0;
      end
      if (prev_stall) chk(cmd_valid && cur === prev_item, "R8 hold while stalled", cur, prev_item);
      if (waiting && !cmd_valid) gap++;
      if (waiting && cmd_valid) begin
        if (n_acc == 1) chk(gap == PWRUP, "R6 power-up wait", gap, PWRUP);
        else chk(gap == GAP, "R7 command gap", gap, GAP);
        waiting = 0;
      end
      if (cmd_valid && cmd_ready) begin
        if (q.size() == 0) chk(0, "R2 extra command", cur, 0);
        else begin
          e = q.pop_front();
          chk(cur === e, "R2/R4/R5 command item", cur, e);
        end
        chk(done === 1'b0, "R9 done low while busy", done, 0);
        n_acc++;
        gap = 0;
        if (n_acc == 14) begin exp_done = 1; n_acc = 0; end
        else waiting = 1;
      end
      prev_stall = cmd_valid && !cmd_ready;
      prev_item = cur;
    end
  end

  task automatic pulse_start();
    @(posedge clk); #1 start = 1;
    @(posedge clk); #1 start = 0;
  endtask

  task automatic set_cfg(input logic [1:0] c, input logic [1:0] r, input bit il, input bit nw);
    @(posedge clk); #1;
    cfg_col = c; cfg_row = r; cfg_interleave = il; cfg_narrow = nw;
  endtask

  task automatic ofs_check(input logic [1:0] c, input logic [1:0] r, input bit il, input bit nw);
    int e;
    set_cfg(c, r, il, nw);
    e = c + 9 + (il ? 0 : r + 11) + (nw ? 1 : 2);
    @(negedge clk);
    chk(bank_ofs == e, "R3 bank offset", bank_ofs, e);
  endtask

  task automatic run_seq(input bit stall, input bit poke);
    stall_mode = stall;
    for (int i = 0; i < 14; i++) q.push_back(exp_item(i));
    pulse_start();
    @(negedge clk);
    chk(done === 1'b0, "R9 start clears done", done, 0);
    if (poke) begin
      // R10: start during the power-up wait
      while (n_acc < 1) @(negedge clk);
      pulse_start();
      // R10: start while a command is stalled
      while (!(n_acc >= 5 && cmd_valid && !cmd_ready)) @(negedge clk);
      @(posedge clk); #1 start = 1;
      @(posedge clk); #1 start = 0;
    end
    while (!done) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(done === 1'b1 && !cmd_valid, "R9 done holds", {done, cmd_valid}, 2'b10);
    chk(q.size() == 0, "R2 all commands issued", q.size(), 0);
    stall_mode = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!cmd_valid && !done, "R1 reset state", {cmd_valid, done}, 0);
    @(posedge clk); #1 rst = 0;

    ofs_check(2'd0, 2'd0, 0, 0);
    ofs_check(2'd1, 2'd2, 1, 1);
    ofs_check(2'd3, 2'd3, 0, 1);
    ofs_check(2'd2, 2'd3, 1, 0);

    run_seq(0, 0);
    set_cfg(2'd3, 2'd1, 0, 1);
    emr1_val = 13'h1386; mr_val = 13'h1FFF; emr2_val = 13'h0005;
    run_seq(1, 1);

    // R1: reset in the middle of a sequence
    for (int i = 0; i < 14; i++) q.push_back(exp_item(i));
    pulse_start();
    while (n_acc < 3) @(negedge clk);
    @(posedge clk); #1 rst = 1;
    @(posedge clk); #1;
    q.delete();
    @(negedge clk);
    chk(!cmd_valid && !done, "R1 reset mid-sequence", {cmd_valid, done}, 0);
    repeat (5) @(negedge clk);
    chk(!cmd_valid && !done, "R1 idle after reset", {cmd_valid, done}, 0);
    @(posedge clk); #1 rst = 0;

    run_seq(0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule